// File: doc/BRIEF.md
# Three-Phase Symmetric Duty Gate Generator

This block drives the twelve gates of an isolated DC-DC converter built from two three-phase bridges, one on each side of the transformer. Both bridges run the same pattern with no phase shift between them. Transferred power is set by one variable, the on-time of each switch within the switching period. Each leg's upper switch conducts for the on-time starting at the leg's phase offset. Its lower switch conducts for the same on-time starting half a period later. The three legs are spaced one third of a period apart.

A synchronous-rectification mode can be selected. In this mode, after a switch ends its on-time, the matching secondary switch stays on for a freewheel interval. The opposite primary switch of the same leg is switched on during that interval, after a dead-time gap, so the freewheeling current flows through a transistor channel and not through a body diode. The freewheel interval is supplied from outside. All timing values are in clock ticks. They are clamped to safe limits and take effect only at a period boundary.

Top module: `dual_bridge_gate_gen`

## Requirements
- R1: Let P be the period input, raised to at least 6 ticks, and let H = floor(P/2) and T = floor(P/3).
  - A tick counter runs 0..P-1 and wraps.
  - Leg k (k = 0, 1, 2 for A, B, C; bit k of each gate bus) has phase offset k*T. Its position is rel = (tick - k*T) mod P.
  - The leg's upper switch is on for 0 <= rel < D.
  - Its lower switch is on for H <= rel < H+D.
- R2: With the rectification mode off, every secondary gate equals the primary gate of the same leg and side in every cycle (zero phase shift).
- R3: A requested on-time below floor(P/6) is raised to floor(P/6).
- R4: The on-time is limited to at most H minus the dead time, so that the upper and lower switches of a leg are never on together.
- R5: With the rectification mode on, a secondary switch stays on for Doff extra ticks after its on-time ends: for D <= rel < D+Doff on the upper side, and for H+D <= rel < H+D+Doff on the lower side.
- R6: With the rectification mode on, the opposite primary switch of that leg is on for D+dead <= rel < D+Doff (primary lower) and for H+D+dead <= rel < H+D+Doff (primary upper). No such pulse appears when Doff <= dead.
- R7: Doff is limited to H - dead - D, so that a held secondary pulse ends at least a dead time before the next switch of that leg turns on.
- R8: Period, on-time, Doff, dead time and mode are sampled only at the last tick of a period, or whenever enable is low. A period never mixes two settings.
- R9: When enable is low, all twelve gates are low from the next clock edge onward. When enable returns, the pattern restarts at tick 0.
- R10: While reset is high, all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| period_i | input | 16 | Switching period in ticks |
| duty_i | input | 16 | Requested on-time in ticks |
| doff_i | input | 16 | Freewheel interval in ticks |
| dead_i | input | 16 | Dead time in ticks |
| sync_rect_i | input | 1 | Synchronous-rectification mode select |
| pri_hi_o | output | 3 | Primary upper gates, bit k = leg k |
| pri_lo_o | output | 3 | Primary lower gates |
| sec_hi_o | output | 3 | Secondary upper gates |
| sec_lo_o | output | 3 | Secondary lower gates |

## Verification
The gates are registered once after the tick counter. The gate pattern for tick k therefore appears after the (k+1)-th rising edge at which enable is seen high. The bench waits that many edges and samples at the following falling edge.

A new setting takes effect from tick 0 of the period after the one in which it was applied. The latch test checks a tick in the current period, which must keep the old pattern, and the same tick one full period later, which must show the new pattern.

Dropping enable clears the gates one edge later, and the bench samples right after that edge.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int TICK_W   = 16;
  localparam int NUM_LEGS = 3;
  typedef logic [TICK_W-1:0] tick_t;
  typedef struct packed {
    tick_t per;
    tick_t half;
    tick_t third;
    tick_t duty;
    tick_t doff;
    tick_t dead;
    logic  sync_rect;
  } cfg_t;

  function automatic tick_t tmin(input tick_t a, input tick_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic tick_t tmax(input tick_t a, input tick_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dbg_cfg_latch.sv
module dbg_cfg_latch
  import dbg_pkg::*;
#(
  parameter int MIN_PERIOD = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  tick_t period_i,
  input  tick_t duty_i,
  input  tick_t doff_i,
  input  tick_t dead_i,
  input  logic  sync_rect_i,
  output cfg_t  cfg_o
);
  localparam tick_t MIN_PER = tick_t'(MIN_PERIOD);

  tick_t per_c, half_c, third_c, sixth_c, dmax_c, duty_c, room_c, doff_c;
  cfg_t  cfg_q;

  // Clamp chain: period floor, then on-time floor/ceiling, then freewheel room.
  always_comb begin
    per_c   = tmax(period_i, MIN_PER);
    half_c  = per_c >> 1;
    third_c = per_c / tick_t'(3);
    sixth_c = per_c / tick_t'(6);
    dmax_c  = (dead_i >= half_c) ? '0 : half_c - dead_i;
    duty_c  = tmin(tmax(duty_i, sixth_c), dmax_c);
    room_c  = ((dead_i + duty_c) >= half_c) ? '0 : half_c - dead_i - duty_c;
    doff_c  = tmin(doff_i, room_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cfg_q.per <= MIN_PER;
    end else if (load) begin
      cfg_q.per       <= per_c;
      cfg_q.half      <= half_c;
      cfg_q.third     <= third_c;
      cfg_q.duty      <= duty_c;
      cfg_q.doff      <= doff_c;
      cfg_q.dead      <= dead_i;
      cfg_q.sync_rect <= sync_rect_i;
    end
  end

  assign cfg_o = cfg_q;

  // R4: latched on-time leaves at least the dead time before the half period
  a_r4_dead_room: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.duty == '0) ||
    (({1'b0, cfg_q.duty} + {1'b0, cfg_q.dead}) <= {1'b0, cfg_q.half}));

  // R7: held secondary pulse plus dead time fits inside the half period
  a_r7_doff_room: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.doff == '0) ||
    (({2'b0, cfg_q.duty} + {2'b0, cfg_q.doff} + {2'b0, cfg_q.dead}) <= {2'b0, cfg_q.half}));

  // R3: on-time never below a sixth of the period unless the dead-time ceiling binds
  a_r3_duty_floor: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.duty >= (cfg_q.per / tick_t'(6))) ||
    (({1'b0, cfg_q.duty} + {1'b0, cfg_q.dead}) >= {1'b0, cfg_q.half}));
endmodule

// File: rtl/dbg_period_cnt.sv
module dbg_period_cnt
  import dbg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  tick_t per,
  output tick_t cnt_o,
  output logic  wrap_o
);
  tick_t cnt_q;

  assign wrap_o = run && (cnt_q == per - tick_t'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + tick_t'(1);
  end

  assign cnt_o = cnt_q;

  // R1: tick stays inside the latched period
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q < per);

  // R9: idle counter restarts from tick 0
  a_r9_cnt_restart: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/dbg_leg.sv
module dbg_leg
  import dbg_pkg::*;
(
  input  tick_t cnt_i,
  input  tick_t off_i,
  input  tick_t per_i,
  input  tick_t half_i,
  input  tick_t duty_i,
  input  tick_t doff_i,
  input  tick_t dead_i,
  input  logic  sync_rect_i,
  output logic  pri_hi_o,
  output logic  pri_lo_o,
  output logic  sec_hi_o,
  output logic  sec_lo_o
);
  tick_t rel;
  tick_t lo_end;
  logic  hi_main, lo_main, hi_hold, lo_hold, fw_lo, fw_hi;

  always_comb begin
    rel     = (cnt_i >= off_i) ? cnt_i - off_i : cnt_i + (per_i - off_i);
    lo_end  = half_i + duty_i;
    hi_main = rel < duty_i;
    lo_main = (rel >= half_i) && (rel < lo_end);
    // Secondary keeps conducting through the freewheel interval.
    hi_hold = sync_rect_i && (rel >= duty_i) && (rel < duty_i + doff_i);
    lo_hold = sync_rect_i && (rel >= lo_end) && (rel < lo_end + doff_i);
    // Opposite primary switch takes the freewheel current after the dead gap.
    fw_lo   = sync_rect_i && (rel >= duty_i + dead_i) && (rel < duty_i + doff_i);
    fw_hi   = sync_rect_i && (rel >= lo_end + dead_i) && (rel < lo_end + doff_i);
  end

  assign pri_hi_o = hi_main | fw_hi;
  assign pri_lo_o = lo_main | fw_lo;
  assign sec_hi_o = hi_main | hi_hold;
  assign sec_lo_o = lo_main | lo_hold;
endmodule

// File: rtl/dual_bridge_gate_gen.sv
module dual_bridge_gate_gen
  import dbg_pkg::*;
#(
  parameter int MIN_PERIOD = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [TICK_W-1:0]   period_i,
  input  logic [TICK_W-1:0]   duty_i,
  input  logic [TICK_W-1:0]   doff_i,
  input  logic [TICK_W-1:0]   dead_i,
  input  logic                sync_rect_i,
  output logic [NUM_LEGS-1:0] pri_hi_o,
  output logic [NUM_LEGS-1:0] pri_lo_o,
  output logic [NUM_LEGS-1:0] sec_hi_o,
  output logic [NUM_LEGS-1:0] sec_lo_o
);
  cfg_t  cfg_q;
  tick_t cnt;
  logic  wrap;
  logic  load;
  logic [NUM_LEGS-1:0] pri_hi_c, pri_lo_c, sec_hi_c, sec_lo_c;

  assign load = !en_i || wrap;

  dbg_cfg_latch #(.MIN_PERIOD(MIN_PERIOD)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .doff_i      (doff_i),
    .dead_i      (dead_i),
    .sync_rect_i (sync_rect_i),
    .cfg_o       (cfg_q)
  );

  dbg_period_cnt u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (en_i),
    .per    (cfg_q.per),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    tick_t off_k;
    assign off_k = tick_t'(k) * cfg_q.third;

    dbg_leg u_leg (
      .cnt_i       (cnt),
      .off_i       (off_k),
      .per_i       (cfg_q.per),
      .half_i      (cfg_q.half),
      .duty_i      (cfg_q.duty),
      .doff_i      (cfg_q.doff),
      .dead_i      (cfg_q.dead),
      .sync_rect_i (cfg_q.sync_rect),
      .pri_hi_o    (pri_hi_c[k]),
      .pri_lo_o    (pri_lo_c[k]),
      .sec_hi_o    (sec_hi_c[k]),
      .sec_lo_o    (sec_lo_c[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      pri_hi_o <= '0;
      pri_lo_o <= '0;
      sec_hi_o <= '0;
      sec_lo_o <= '0;
    end else begin
      pri_hi_o <= pri_hi_c;
      pri_lo_o <= pri_lo_c;
      sec_hi_o <= sec_hi_c;
      sec_lo_o <= sec_lo_c;
    end
  end

  // R4: no leg has both switches on, on either bridge
  a_r4_no_shoot_pri: assert property (@(posedge clk) disable iff (rst)
    (pri_hi_o & pri_lo_o) == '0);
  a_r4_no_shoot_sec: assert property (@(posedge clk) disable iff (rst)
    (sec_hi_o & sec_lo_o) == '0);

  // R9: gates fall on the edge after enable drops
  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ((pri_hi_o | pri_lo_o | sec_hi_o | sec_lo_o) == '0));

  // R2: bridges match when rectification mode is off
  a_r2_in_phase: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.sync_rect |-> ((pri_hi_c == sec_hi_c) && (pri_lo_c == sec_lo_c)));

  // R6: a forced primary lower pulse only occurs while the secondary upper is held
  a_r6_fw_within_hold: assert property (@(posedge clk) disable iff (rst)
    (pri_lo_c & ~sec_lo_c & ~sec_hi_c) == '0);

  // R10: reset clears the outputs
  a_r10_reset_low: assert property (@(posedge clk)
    rst |=> ((pri_hi_o | pri_lo_o | sec_hi_o | sec_lo_o) == '0));
endmodule

// File: tb/dual_bridge_gate_gen_tb.sv
`timescale 1ns/1ps
module dual_bridge_gate_gen_tb_top;
  import dbg_pkg::*;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] duty;
    logic [15:0] doff;
    logic [15:0] dead;
    logic        sr;
    logic [15:0] tick;
    logic [11:0] exp;   // {pri_hi, pri_lo, sec_hi, sec_lo}, bit k = leg k
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R1: base windows, P=60, D=20
    '{16'd60, 16'd20, 16'd0,  16'd2, 1'b0, 16'd0,  12'b001_010_001_010, 8'd1},
    '{16'd60, 16'd20, 16'd0,  16'd2, 1'b0, 16'd25, 12'b010_100_010_100, 8'd1},
    '{16'd60, 16'd20, 16'd0,  16'd2, 1'b0, 16'd35, 12'b010_001_010_001, 8'd1},
    '{16'd60, 16'd20, 16'd0,  16'd2, 1'b0, 16'd59, 12'b100_010_100_010, 8'd1},
    // R3: D=5 raised to 10
    '{16'd60, 16'd5,  16'd0,  16'd2, 1'b0, 16'd9,  12'b001_000_001_000, 8'd3},
    '{16'd60, 16'd5,  16'd0,  16'd2, 1'b0, 16'd10, 12'b000_100_000_100, 8'd3},
    // R4: D=29 limited to 28
    '{16'd60, 16'd29, 16'd0,  16'd2, 1'b0, 16'd27, 12'b011_100_011_100, 8'd4},
    '{16'd60, 16'd29, 16'd0,  16'd2, 1'b0, 16'd28, 12'b010_100_010_100, 8'd4},
    // R2: start of period with A-hi, B-lo, C-hi on both bridges
    '{16'd60, 16'd25, 16'd0,  16'd2, 1'b0, 16'd0,  12'b101_010_101_010, 8'd2},
    // R5 / R6: rectification mode, D=15, Doff=10, dead=3
    '{16'd60, 16'd15, 16'd10, 16'd3, 1'b1, 16'd16, 12'b000_100_001_100, 8'd5},
    '{16'd60, 16'd15, 16'd10, 16'd3, 1'b1, 16'd20, 12'b010_101_011_100, 8'd6},
    '{16'd60, 16'd15, 16'd10, 16'd3, 1'b1, 16'd25, 12'b010_000_010_100, 8'd5},
    '{16'd60, 16'd15, 16'd10, 16'd3, 1'b1, 16'd50, 12'b101_010_100_011, 8'd6},
    // R7: Doff=20 limited to 12
    '{16'd60, 16'd15, 16'd20, 16'd3, 1'b1, 16'd26, 12'b010_001_011_100, 8'd7},
    '{16'd60, 16'd15, 16'd20, 16'd3, 1'b1, 16'd27, 12'b010_000_010_100, 8'd7},
    // R6: Doff below dead time gives no forced primary pulse
    '{16'd60, 16'd15, 16'd2,  16'd3, 1'b1, 16'd16, 12'b000_100_001_100, 8'd6},
    // R1: period 2 raised to 6
    '{16'd2,  16'd1,  16'd0,  16'd0, 1'b0, 16'd6,  12'b001_000_001_000, 8'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic sr = 1'b0;
  logic [TICK_W-1:0] period = 16'd60, duty = 16'd20, doff = 16'd0, dead = 16'd2;
  logic [NUM_LEGS-1:0] pri_hi, pri_lo, sec_hi, sec_lo;
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dual_bridge_gate_gen dut_i (
    .clk(clk), .rst(rst), .en_i(en), .period_i(period), .duty_i(duty),
    .doff_i(doff), .dead_i(dead), .sync_rect_i(sr),
    .pri_hi_o(pri_hi), .pri_lo_o(pri_lo), .sec_hi_o(sec_hi), .sec_lo_o(sec_lo)
  );

  wire [11:0] gates = {pri_hi, pri_lo, sec_hi, sec_lo};

  task automatic check(input logic [11:0] got, input logic [11:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic start_run();
    @(negedge clk); en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    #(5ns * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state with enable high
    en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gates, 12'b0, "R10 reset");
    en = 1'b0; rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      en = 1'b0;
      period = VECS[i].per; duty = VECS[i].duty; doff = VECS[i].doff;
      dead = VECS[i].dead; sr = VECS[i].sr;
      start_run();
      repeat (int'(VECS[i].tick) + 1) @(posedge clk);
      @(negedge clk);
      check(gates, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R8: change applied mid-period takes effect from the next period
    @(negedge clk);
    en = 1'b0; period = 16'd60; duty = 16'd20; doff = 16'd0; dead = 16'd2; sr = 1'b0;
    start_run();
    repeat (6) @(posedge clk);
    @(negedge clk);
    duty = 16'd10;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check({11'b0, pri_hi[0]}, 12'd1, "R8 old duty kept at tick 15");
    repeat (60) @(posedge clk);
    @(negedge clk);
    check({11'b0, pri_hi[0]}, 12'd0, "R8 new duty at tick 75");

    // R9: enable low clears gates on the next edge
    en = 1'b0; duty = 16'd20;
    @(posedge clk);
    @(negedge clk);
    check(gates, 12'b0, "R9 disable");
    // R9: restart from tick 0
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(gates, 12'b001_010_001_010, "R9 restart tick 0");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule